// File: doc/BRIEF.md
# UART Modem Line Control and Status

This block holds the modem control and modem status registers of a UART and drives the hardware flow-control pins. A processor reaches both registers over a simple single-cycle register bus. The bus has an address, a write strobe, a read strobe and write data, and the read data is combinational. The control register chooses between manual and automatic flow control and sets up loopback. The status register shows the current clear-to-send level and a sticky change flag.

The active-low clear-to-send pin passes through a two-flop synchronizer and is then inverted. In loopback the request-to-send control bit takes the place of the pin. This internal level is registered, and any change sets the change flag. Reading the status register clears the flag, and an interrupt is raised while the flag is set and the interrupt enable is on.

Under automatic flow control the block withholds transmit permission while CTS is inactive. When the full automatic mode is chosen, it also drives the request-to-send pin from the receive FIFO almost-full flag. The transmitter finishes the character it has started before it stops, and it later resumes from where it stopped. FIFO contents are never touched.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset the control register reads 0x00, the status change flag is 0, `nrts_pin` is 1, `tx_permit` is 1 and `msi_irq` is 0.
- R2: A write to the control address (3'd4) stores auto-flow enable at bit 5, loopback at bit 4, OUT2 at bit 3 and RTS at bit 1. A read of that address returns exactly these bits, and every other bit reads 0.
- R3: A read of the status address (3'd6) returns the CTS level at bit 4 and the CTS change flag at bit 0, with all other bits 0. Outside loopback, the CTS level is the inverse of `ncts_pin` and appears on the third rising clock edge after the pin changes.
- R4: The change flag is set on the rising edge at which the registered CTS level takes a new value. A status read returns the flag's value before that read, and the flag is cleared on the edge that ends the read.
- R5: When a CTS change and a status read fall on the same edge, the flag ends up set.
- R6: A write to the status address changes neither register.
- R7: `msi_irq` is 1 exactly while the change flag is 1 and `msi_en` is 1.
- R8: With auto-flow disabled, `nrts_pin` equals the inverse of RTS and `tx_permit` is 1.
- R9: With auto-flow enabled, `tx_permit` equals the registered CTS level.
- R10: With auto-flow enabled and RTS=1, `nrts_pin` follows `rx_almost_full`. With auto-flow enabled and RTS=0, `nrts_pin` is 1.
- R11: In loopback the internal CTS level equals the RTS bit one edge after it is written, and `ncts_pin` has no effect on the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (3) | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational |
| ncts_pin | input | 1 | External clear-to-send, active low, asynchronous |
| msi_en | input | 1 | Modem status interrupt enable |
| rx_almost_full | input | 1 | Receive FIFO almost-full flag |
| nrts_pin | output | 1 | Request-to-send pin, active low |
| tx_permit | output | 1 | Transmitter may start a new character |
| msi_irq | output | 1 | Modem status interrupt request |

## Verification
The results fall due at different times. Control-register writes show up on the read data and on the pins one edge after the write strobe. A pin change on `ncts_pin` reaches the status bit and the change flag on the third edge, and a loopback RTS write reaches them on the second edge. The clear-on-read takes effect on the edge that ends the read. The bench drives every input at the falling edge and samples one time unit later or at a following falling edge. It waits at least four cycles after a pin change before it reads, and it places the collision read on exactly the third edge.

// File: rtl/uart_mdm_pkg.sv
package uart_mdm_pkg;
  localparam int CB_AFE  = 5;
  localparam int CB_LOOP = 4;
  localparam int CB_OUT2 = 3;
  localparam int CB_RTS  = 1;
  localparam int SB_CTS  = 4;
  localparam int SB_DCTS = 0;

  typedef struct packed {
    logic afe;
    logic loop;
    logic out2;
    logic rts;
  } mctl_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], d_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= {STAGES{RST_VAL}};
    else        sr_q <= sr_d;
  end

  assign d_out = sr_q[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import uart_mdm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output mctl_t             ctrl_q
);
  mctl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.afe  = wdata[CB_AFE];
      ctrl_d.loop = wdata[CB_LOOP];
      ctrl_d.out2 = wdata[CB_OUT2];
      ctrl_d.rts  = wdata[CB_RTS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata;
endmodule

// File: rtl/mdm_status.sv
module mdm_status (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_in,
  input  logic rd_clr,
  output logic cts_q,
  output logic dcts_q
);
  logic cts_d;
  logic dcts_d;
  logic change;

  always_comb begin
    change = (cts_in != cts_q);
    cts_d  = cts_in;
    dcts_d = dcts_q;
    if (rd_clr) dcts_d = 1'b0;
    if (change) dcts_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_q  <= 1'b0;
      dcts_q <= 1'b0;
    end else begin
      cts_q  <= cts_d;
      dcts_q <= dcts_d;
    end
  end
endmodule

// File: rtl/mdm_flow.sv
module mdm_flow
  import uart_mdm_pkg::*;
(
  input  mctl_t ctrl,
  input  logic  cts,
  input  logic  rx_af,
  output logic  nrts,
  output logic  tx_ok
);
  always_comb begin
    if (ctrl.afe) begin
      tx_ok = cts;
      nrts  = ctrl.rts ? rx_af : 1'b1;
    end else begin
      tx_ok = 1'b1;
      nrts  = ~ctrl.rts;
    end
  end
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import uart_mdm_pkg::*;
#(
  parameter int              DATA_W      = 32,
  parameter int              ADDR_W      = 3,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 3'd4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 3'd6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ncts_pin,
  input  logic              msi_en,
  input  logic              rx_almost_full,
  output logic              nrts_pin,
  output logic              tx_permit,
  output logic              msi_irq
);
  logic  ctrl_wr;
  logic  stat_rd;
  mctl_t ctrl_q;
  logic  ncts_sync;
  logic  cts_int;
  logic  cts_q;
  logic  dcts_q;

  assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);
  assign stat_rd = bus_rd && (bus_addr == STAT_ADDR);

  mdm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (ncts_pin),
    .d_out (ncts_sync)
  );

  mdm_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctrl_wr),
    .wdata  (bus_wdata),
    .ctrl_q (ctrl_q)
  );

  assign cts_int = ctrl_q.loop ? ctrl_q.rts : ~ncts_sync;

  mdm_status u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .cts_in (cts_int),
    .rd_clr (stat_rd),
    .cts_q  (cts_q),
    .dcts_q (dcts_q)
  );

  mdm_flow u_flow (
    .ctrl  (ctrl_q),
    .cts   (cts_q),
    .rx_af (rx_almost_full),
    .nrts  (nrts_pin),
    .tx_ok (tx_permit)
  );

  assign msi_irq = msi_en & dcts_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == CTRL_ADDR) begin
        bus_rdata[CB_AFE]  = ctrl_q.afe;
        bus_rdata[CB_LOOP] = ctrl_q.loop;
        bus_rdata[CB_OUT2] = ctrl_q.out2;
        bus_rdata[CB_RTS]  = ctrl_q.rts;
      end else if (bus_addr == STAT_ADDR) begin
        bus_rdata[SB_CTS]  = cts_q;
        bus_rdata[SB_DCTS] = dcts_q;
      end
    end
  end
endmodule

// File: rtl/mdm_checker.sv
module mdm_checker
  import uart_mdm_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                ADDR_W    = 3,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 3'd6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              msi_en,
  input logic              rx_almost_full,
  input logic              nrts_pin,
  input logic              tx_permit,
  input logic              msi_irq,
  input mctl_t             ctrl,
  input logic              cts_int,
  input logic              cts_q,
  input logic              dcts_q
);
  assert_delta_on_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_q != $past(cts_q)) |-> dcts_q);

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == STAT_ADDR && cts_int == cts_q) |=> !dcts_q);

  assert_collision_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == STAT_ADDR && cts_int != cts_q) |=> dcts_q);

  assert_stat_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == STAT_ADDR) |=> $stable(ctrl));

  assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msi_irq |-> msi_en);

  assert_manual_rts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.afe |-> (nrts_pin == !ctrl.rts) && tx_permit);

  assert_auto_cts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.afe |-> (tx_permit == cts_q));

  assert_full_auto_rts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.afe && ctrl.rts) |-> (nrts_pin == rx_almost_full));

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (bus_rdata[DATA_W-1:6] == '0) && !bus_rdata[2]);
endmodule

bind uart_modem_ctl mdm_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_addr       (bus_addr),
  .bus_wr         (bus_wr),
  .bus_rd         (bus_rd),
  .bus_rdata      (bus_rdata),
  .msi_en         (msi_en),
  .rx_almost_full (rx_almost_full),
  .nrts_pin       (nrts_pin),
  .tx_permit      (tx_permit),
  .msi_irq        (msi_irq),
  .ctrl           (ctrl_q),
  .cts_int        (cts_int),
  .cts_q          (cts_q),
  .dcts_q         (dcts_q)
);

// File: tb/uart_modem_ctl_bench.sv
`timescale 1ns/1ps
module uart_modem_ctl_bench;
  localparam logic [2:0] A_CTRL = 3'd4;
  localparam logic [2:0] A_STAT = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ncts_pin = 1'b1;
  logic        msi_en = 1'b0;
  logic        rx_almost_full = 1'b0;
  logic        nrts_pin;
  logic        tx_permit;
  logic        msi_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_modem_ctl u_uart_modem_ctl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ncts_pin(ncts_pin), .msi_en(msi_en), .rx_almost_full(rx_almost_full),
    .nrts_pin(nrts_pin), .tx_permit(tx_permit), .msi_irq(msi_irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
    rd(A_STAT, d); chk("R1 status", d, 32'h0);
    chk("R1 nrts", {31'b0, nrts_pin}, 32'h1);
    chk("R1 tx_permit", {31'b0, tx_permit}, 32'h1);
    chk("R1 irq", {31'b0, msi_irq}, 32'h0);

    // R3/R4/R7: pin edge timing, clear-on-read, irq gating
    msi_en = 1'b1;
    ncts_pin = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3 no early change", {31'b0, msi_irq}, 32'h0);
    @(negedge clk);
    chk("R7 irq on delta", {31'b0, msi_irq}, 32'h1);
    msi_en = 1'b0;
    #1 chk("R7 irq masked", {31'b0, msi_irq}, 32'h0);
    msi_en = 1'b1;
    rd(A_STAT, d); chk("R4 read shows delta", d, 32'h11);
    rd(A_STAT, d); chk("R4 cleared after read", d, 32'h10);
    chk("R7 irq drops", {31'b0, msi_irq}, 32'h0);

    // R5: change lands on the read edge
    ncts_pin = 1'b1;
    repeat (2) @(negedge clk);
    rd(A_STAT, d); chk("R5 pre-value", d, 32'h10);
    rd(A_STAT, d); chk("R5 flag kept", d, 32'h01);
    rd(A_STAT, d); chk("R5 then cleared", d, 32'h00);

    // R6: write to status address ignored
    wr(A_CTRL, 32'h0000_0008);
    wr(A_STAT, 32'hFFFF_FFFF);
    settle();
    rd(A_CTRL, d); chk("R6 ctrl kept", d, 32'h08);
    rd(A_STAT, d); chk("R6 status kept", d, 32'h00);

    // R11: loopback one-edge timing and pin isolation
    wr(A_CTRL, 32'h0000_0012);
    @(negedge clk);
    rd(A_STAT, d); chk("R11 loop cts", d, 32'h11);
    ncts_pin = 1'b0; settle();
    rd(A_STAT, d); chk("R11 pin ignored", d, 32'h10);
    ncts_pin = 1'b1;
    wr(A_CTRL, 32'h0000_0010);
    @(negedge clk);
    rd(A_STAT, d); chk("R11 loop cts low", d, 32'h01);
    rd(A_STAT, d);

    // R2/R8/R9/R10/R11/R3: sweep of all control bits, FIFO flag and pin
    for (int c = 0; c < 16; c++) begin
      for (int af = 0; af < 2; af++) begin
        for (int p = 0; p < 2; p++) begin
          logic afe, lp, o2, rt, exp_cts, exp_nrts, exp_tx;
          logic [31:0] wv;
          afe = c[3]; lp = c[2]; o2 = c[1]; rt = c[0];
          wv = 32'hFFFF_FFC5 | ({26'b0, afe, lp, o2, 1'b0, rt, 1'b0});
          wv = wv & ~32'h3A | ({26'b0, afe, lp, o2, 1'b0, rt, 1'b0});
          wr(A_CTRL, wv);
          rx_almost_full = af[0];
          ncts_pin = p[0];
          settle();
          rd(A_STAT, d);
          rd(A_STAT, d);
          exp_cts  = lp ? rt : ~p[0];
          exp_nrts = afe ? (rt ? af[0] : 1'b1) : ~rt;
          exp_tx   = afe ? exp_cts : 1'b1;
          chk("R3/R11 cts level", d, {27'b0, exp_cts, 4'b0});
          chk("R8/R10 nrts", {31'b0, nrts_pin}, {31'b0, exp_nrts});
          chk("R8/R9 tx_permit", {31'b0, tx_permit}, {31'b0, exp_tx});
          rd(A_CTRL, d);
          chk("R2 ctrl readback", d, {26'b0, afe, lp, o2, 1'b0, rt, 1'b0});
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule